// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software programs it through a small write port. The port holds a control byte, a sticky completion flag and a high/low pair of 8-bit result registers. Setting the start bit, while the converter is already enabled, opens the sample-and-hold switch. The sequencer then walks the trial code from the most significant bit down to the least significant bit, advancing one step per conversion-clock period. At each step it asks an external comparator whether the held input is at or above the trial code.

After the last decision, the 10-bit code goes into the result pair in one of two layouts. In the right-aligned layout the code is packed into the low end of the pair. In the left-aligned layout it is packed into the high end. On the same edge the start/busy bit clears, the completion flag sets and the sample switch closes again.

Software can abort a conversion by clearing the start bit. An abort leaves the result pair untouched and closes the sample switch, so acquisition resumes at once. While the converter is disabled, the result pair is plain read/write storage.

Top module: `sar_seq`

## Requirements
- R1: A control write that sets the start bit (bit 1) while the converter was disabled before that write does not start a conversion. This holds even when the same write also sets the enable bit (bit 0): busy stays 0, and no result or flag changes.
- R2: A control write (address 0) with enable and start both set, while enabled and idle, raises busy and opens the sample switch (sh_connect_o = 0). The conversion ends exactly 11*N clock cycles after that write edge. N is 2, 8 or 32 for divider select (bits 4:3) equal to 0, 1 or 2/3.
- R3: Bits are decided MSB first. A bit is kept when comp_i is 1, meaning the input is at or above the trial code on sar_o. With a comparator that tracks a held input, the final code equals that input.
- R4: With the format bit (bit 2) at 1, completion loads res_hi_o = {6'b0, code[9:8]} and res_lo_o = code[7:0].
- R5: With the format bit at 0, completion loads res_hi_o = code[9:2] and res_lo_o = {code[1:0], 6'b0}.
- R6: On the completing edge, busy clears, the completion flag sets and the sample switch closes (sh_connect_o = 1).
- R7: A control write with the start bit at 0 during a conversion aborts it on that edge. Busy clears, the sample switch closes, and both result registers keep their previous values. A later start converts normally.
- R8: The completion flag (address 1, bit 0) stays set until a write of 0 to that bit. A write of 1 has no effect.
- R9: The result registers (address 2 high, address 3 low) take software writes whether the converter is disabled, idle or converting. A completion overwrites both.
- R10: After reset, busy, the completion flag, the sample switch output and both result registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 flag, 2 result high, 3 result low |
| wr_data_i | input | 8 | Write data |
| comp_i | input | 1 | Comparator decision: 1 when the input is at or above sar_o |
| sar_o | output | 10 | Current trial code for the DAC |
| sh_connect_o | output | 1 | Sample switch closed (acquiring) |
| busy_o | output | 1 | Start/busy bit |
| done_o | output | 1 | Sticky completion flag |
| res_hi_o | output | 8 | Result register, high byte |
| res_lo_o | output | 8 | Result register, low byte |

## Verification
The conversion path is driven with random held input codes under random layout and divider choices. It is also driven with directed extremes: all zeros, all ones, a lone MSB and alternating patterns. The extremes separate a wrong keep/clear decision on a single bit from a shifted or misplaced field in either layout. The per-select cycle count separates the three divider settings, and tells whether the first period is shortened or padded. Further directed sequences cover three cases: an enable-and-start write, an abort followed by a restart, and software writes landing mid-conversion. These show whether the result pair is disturbed only by completion.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    DIV_FAST  = 2'd0,
    DIV_MID   = 2'd1,
    DIV_SLOW  = 2'd2,
    DIV_SLOW2 = 2'd3
  } div_sel_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_RHI  = 2'd2;
  localparam logic [1:0] ADDR_RLO  = 2'd3;

  localparam int BIT_EN  = 0;
  localparam int BIT_GO  = 1;
  localparam int BIT_FMT = 2;
  localparam int BIT_SEL = 3;
endpackage

// File: rtl/sar_tad_div.sv
`timescale 1ns/1ps
module sar_tad_div
  import sar_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     clr_i,
  input  div_sel_e sel_i,
  output logic     tick_o
);
  localparam int CW = $clog2(DIV_C);

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      DIV_FAST: lim = CW'(DIV_A - 1);
      DIV_MID:  lim = CW'(DIV_B - 1);
      default:  lim = CW'(DIV_C - 1);
    endcase
  end

  // >= keeps the strobe alive if the select shrinks mid-period
  assign tick_o = run_i & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_step.sv
`timescale 1ns/1ps
module sar_step #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic             comp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] sar_o,
  output logic             fin_o,
  output logic [RES_W-1:0] res_o
);
  localparam int SW = $clog2(RES_W + 1);
  localparam logic [SW-1:0] LAST = SW'(RES_W);

  logic             busy_q;
  logic [SW-1:0]    step_q;
  logic [RES_W-1:0] sar_q, sar_nxt;

  // step 0: place MSB trial; step k: decide bit RES_W-k, place next trial
  always_comb begin
    sar_nxt = sar_q;
    if (step_q == '0) begin
      sar_nxt[RES_W-1] = 1'b1;
    end else begin
      for (int i = 0; i < RES_W; i++) begin
        if (i == RES_W - int'(step_q) && !comp_i) sar_nxt[i] = 1'b0;
      end
      for (int i = 0; i < RES_W - 1; i++) begin
        if (i + 1 == RES_W - int'(step_q)) sar_nxt[i] = 1'b1;
      end
    end
  end

  assign fin_o  = busy_q & tick_i & ~abort_i & (step_q == LAST);
  assign res_o  = sar_nxt;
  assign busy_o = busy_q;
  assign sar_o  = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      sar_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
      sar_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      step_q <= '0;
      sar_q  <= '0;
    end else if (busy_q && tick_i) begin
      sar_q <= sar_nxt;
      if (step_q == LAST) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_justify.sv
`timescale 1ns/1ps
module sar_justify #(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             right_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int PW  = 2 * REG_W;
  localparam int PAD = PW - RES_W;

  logic [PW-1:0] pair;

  assign pair = right_i ? PW'(res_i) : {res_i, {PAD{1'b0}}};
  assign hi_o = pair[PW-1:REG_W];
  assign lo_o = pair[REG_W-1:0];
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int REG_W = 8,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] sar_o,
  output logic             sh_connect_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  logic       en_q, fmt_q, done_q;
  div_sel_e   sel_q;
  logic [REG_W-1:0] hi_q, lo_q, hi_fmt, lo_fmt;
  logic       wr_ctrl, wr_flag, wr_hi, wr_lo;
  logic       start, abort, tick, fin, busy;
  logic [RES_W-1:0] res;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_FLAG);
  assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_RHI);
  assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_RLO);

  // start only counts when already enabled before this write
  assign start = wr_ctrl & wr_data_i[BIT_EN] & wr_data_i[BIT_GO] & en_q & ~busy;
  assign abort = wr_ctrl & busy & (~wr_data_i[BIT_GO] | ~wr_data_i[BIT_EN]);

  sar_tad_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .clr_i  (start),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  sar_step #(.RES_W(RES_W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .tick_i  (tick),
    .comp_i  (comp_i),
    .busy_o  (busy),
    .sar_o   (sar_o),
    .fin_o   (fin),
    .res_o   (res)
  );

  sar_justify #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
    .res_i   (res),
    .right_i (fmt_q),
    .hi_o    (hi_fmt),
    .lo_o    (lo_fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      fmt_q <= 1'b0;
      sel_q <= DIV_FAST;
    end else if (wr_ctrl) begin
      en_q  <= wr_data_i[BIT_EN];
      fmt_q <= wr_data_i[BIT_FMT];
      sel_q <= div_sel_e'(wr_data_i[BIT_SEL +: 2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      done_q <= 1'b0;
    else if (fin)                     done_q <= 1'b1;
    else if (wr_flag && !wr_data_i[0]) done_q <= 1'b0;
  end

  // completion beats a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin) begin
      hi_q <= hi_fmt;
      lo_q <= lo_fmt;
    end else begin
      if (wr_hi) hi_q <= wr_data_i;
      if (wr_lo) lo_q <= wr_data_i;
    end
  end

  assign busy_o       = busy;
  assign done_o       = done_q;
  assign sh_connect_o = en_q & ~busy;
  assign res_hi_o     = hi_q;
  assign res_lo_o     = lo_q;
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             sh_connect_o,
  input logic [REG_W-1:0] res_hi_o,
  input logic [REG_W-1:0] res_lo_o,
  input logic             en_q,
  input logic             fin
);
  p_start_needs_enable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_q));

  p_switch_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sh_connect_o);

  p_finish_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> (done_o && !busy_o && sh_connect_o));

  p_abort_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && wr_addr_i == 2'd0 && !wr_data_i[1]) |=> !busy_o);

  p_result_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fin && !(wr_en_i && wr_addr_i[1])) |=> ($stable(res_hi_o) && $stable(res_lo_o)));

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(wr_en_i && wr_addr_i == 2'd1 && !wr_data_i[0])) |=> done_o);
endmodule

bind sar_seq sar_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .sh_connect_o (sh_connect_o),
  .res_hi_o     (res_hi_o),
  .res_lo_o     (res_lo_o),
  .en_q         (en_q),
  .fin          (fin)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] vin = '0;
  logic [9:0] sar;
  logic       comp, sh, busy, done;
  logic [7:0] rhi, rlo;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign comp = (vin >= sar);

  sar_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .comp_i(comp), .sar_o(sar), .sh_connect_o(sh),
    .busy_o(busy), .done_o(done), .res_hi_o(rhi), .res_lo_o(rlo)
  );

  function automatic int divn(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic f);
    return f ? {6'b0, v[9:8]} : v[9:2];
  endfunction

  function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic f);
    return f ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_conv(input logic [9:0] v, input logic f, input logic [1:0] s);
    int cyc;
    logic [9:0] back;
    vin = v;
    wr(2'd1, 8'h00);
    chk("R8 flag cleared by zero write", done, 0);
    wr(2'd0, {3'b0, s, f, 2'b01});
    wr(2'd0, {3'b0, s, f, 2'b11});
    chk("R2 busy after start", busy, 1);
    chk("R2 switch open", sh, 0);
    cyc = 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R2 conversion length", cyc, 11 * divn(s));
    chk("R6 busy clear", busy, 0);
    chk("R6 flag set", done, 1);
    chk("R6 switch closed", sh, 1);
    if (f) begin
      chk("R4 right high", rhi, exp_hi(v, f));
      chk("R4 right low", rlo, exp_lo(v, f));
      back = {rhi[1:0], rlo};
    end else begin
      chk("R5 left high", rhi, exp_hi(v, f));
      chk("R5 left low", rlo, exp_lo(v, f));
      back = {rhi, rlo[7:6]};
    end
    chk("R3 code equals input", back, v);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] h0, l0;
    void'($urandom(32'h5A17));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R10 busy", busy, 0);
    chk("R10 flag", done, 0);
    chk("R10 switch", sh, 0);
    chk("R10 high", rhi, 0);
    chk("R10 low", rlo, 0);

    // R9 plain storage while disabled
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h3C);
    chk("R9 high rw disabled", rhi, 8'hA5);
    chk("R9 low rw disabled", rlo, 8'h3C);

    // R1 enable and start together are ignored
    vin = 10'h3FF;
    wr(2'd0, 8'h03);
    chk("R1 no start", busy, 0);
    idle(40);
    chk("R1 no flag", done, 0);
    chk("R1 high untouched", rhi, 8'hA5);
    chk("R1 low untouched", rlo, 8'h3C);

    // directed extremes
    run_conv(10'h000, 1'b1, 2'd0);
    run_conv(10'h3FF, 1'b0, 2'd0);
    run_conv(10'h200, 1'b1, 2'd1);
    run_conv(10'h155, 1'b0, 2'd2);
    run_conv(10'h2AA, 1'b1, 2'd3);
    run_conv(10'h001, 1'b0, 2'd1);

    // R8 write of one keeps flag
    wr(2'd1, 8'h01);
    chk("R8 one write keeps flag", done, 1);
    idle(5);
    chk("R8 flag sticky", done, 1);
    wr(2'd1, 8'h00);
    chk("R8 zero write clears", done, 0);

    // R7 abort
    run_conv(10'h2AB, 1'b1, 2'd0);
    h0 = rhi; l0 = rlo;
    wr(2'd1, 8'h00);
    vin = 10'h0F0;
    wr(2'd0, 8'h0F);
    chk("R7 started", busy, 1);
    idle(20);
    wr(2'd0, 8'h0D);
    chk("R7 abort clears busy", busy, 0);
    chk("R7 switch closes", sh, 1);
    idle(400);
    chk("R7 high kept", rhi, h0);
    chk("R7 low kept", rlo, l0);
    chk("R7 no flag", done, 0);
    run_conv(10'h0F0, 1'b1, 2'd1);

    // R9 write during conversion, then overwrite by completion
    vin = 10'h31C;
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h13);
    wr(2'd2, 8'h77);
    chk("R9 write mid conversion", rhi, 8'h77);
    chk("R9 still busy", busy, 1);
    while (busy) @(negedge clk);
    chk("R9 overwrite high", rhi, exp_hi(10'h31C, 1'b0));
    chk("R9 overwrite low", rlo, exp_lo(10'h31C, 1'b0));

    // random conversions
    for (int k = 0; k < 40; k++) begin
      run_conv(10'($urandom), 1'($urandom), 2'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule